// File: doc/BRIEF.md
# Interrupt Priority Sorter with Spurious Flag

This block is the decision core of a vectored interrupt controller. It watches a vector of level-sensitive request lines and holds a per-line mask bit and a per-line priority value. When any unmasked request is pending while the sorter is idle, it starts a sort. The sort takes a fixed window of `SORT_CYCLES` clock cycles and scans a fixed slice of candidates in each cycle. At the end of the window it publishes the winning line number and that line's priority. It then raises an interrupt line to the processor.

A result can go stale while the sort is running. This happens when the line that started the sort drops, or when a mask write removes the line that was about to win. In either case the result is still published, but with a spurious bit set, so that software knows to acknowledge it and try again. An acknowledge write releases the result and lets the sorter run again. No new sort starts until that acknowledge arrives.

The state machine has three states:
- `ST_IDLE` goes to `ST_SORT` (the start transition) when an unmasked request is pending.
- `ST_SORT` goes to `ST_HOLD` (the publish transition) after its last scan cycle.
- `ST_HOLD` goes to `ST_IDLE` (the release transition) on an acknowledge.

Top module: `irqsort_core`

## Requirements
- R1: After reset, `cpu_irq` is low, `status_word` is zero and every line is masked (mask bit 1 = masked).
- R2: An unmasked pending request seen by a clock edge in `ST_IDLE` starts a sort at that edge. `cpu_irq` rises exactly `SORT_CYCLES` (10) edges later.
- R3: The winner is the pending line with the smallest priority value; on a tie the lower line number wins. `status_word` bits [6:0] hold the winning number and bits [13:8] its priority.
- R4: Masked lines neither start a sort nor compete in one.
- R5: The trigger is the lowest-numbered unmasked line pending at the start edge. If it is low at any edge of the window, the spurious bit (`status_word` bit 31) is set. Dropping any other line leaves the bit clear.
- R6: If the mask in force at the final edge of the window masks the winner, the spurious bit is set. Masking a line that would not have won leaves the bit clear and the winner unchanged.
- R7: Requests that rise during the window do not compete and do not set the spurious bit. Priority writes during the window do not set the spurious bit.
- R8: While in `ST_HOLD`, `cpu_irq` stays high and `status_word` stays constant until an acknowledge, whatever the requests do.
- R9: An acknowledge in `ST_HOLD` drops `cpu_irq` at that edge. If an unmasked request is still pending, a new sort starts on the following edge; otherwise the sorter stays idle.
- R10: An acknowledge outside `ST_HOLD` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | NUM_IRQ | Level-sensitive request lines |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | NUM_IRQ | New mask vector (1 = masked) |
| prio_we | input | 1 | Priority write strobe |
| prio_idx | input | NUM_W | Line whose priority is written |
| prio_wdata | input | PRIO_W | New priority value (lower = more urgent) |
| ack_we | input | 1 | Acknowledge write |
| cpu_irq | output | 1 | Interrupt to the processor |
| status_word | output | STAT_W | {spurious, 0, priority[13:8], 0, number[6:0]} |

## Verification
On every cycle, the assertions check the following:
- the processor interrupt stays held until an acknowledge;
- it falls after an acknowledge;
- the result word is frozen while the interrupt is held;
- a rise of the interrupt always follows exactly one full sort window.

Only the bench's scenarios can show which line wins and when the spurious bit is set. These depend on which line started the sort, on when a request drops, and on which mask bits change within the window. The bench computes each expected winner from its own copy of the priorities and the request pattern.

// File: rtl/irqsort_pkg.sv
package irqsort_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SORT = 2'd1,
        ST_HOLD = 2'd2
    } sort_state_e;
endpackage

// File: rtl/irqsort_first.sv
// Lowest-numbered set bit finder, used to pick the trigger line.
module irqsort_first #(
    parameter int NUM_IRQ = 128,
    localparam int NUM_W  = $clog2(NUM_IRQ)
) (
    input  logic [NUM_IRQ-1:0] vec,
    output logic               found,
    output logic [NUM_W-1:0]   idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_IRQ - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = NUM_W'(i);
            end
        end
    end
endmodule

// File: rtl/irqsort_chunk.sv
// One scan step: best candidate among LANES lines of slice chunk_idx.
// Ascending scan with strict compare keeps the lower number on ties.
module irqsort_chunk #(
    parameter int NUM_IRQ = 128,
    parameter int PRIO_W  = 6,
    parameter int LANES   = 13,
    parameter int CNT_W   = 4,
    localparam int NUM_W  = $clog2(NUM_IRQ)
) (
    input  logic [CNT_W-1:0]                chunk_idx,
    input  logic [NUM_IRQ-1:0]              cand,
    input  logic [NUM_IRQ-1:0][PRIO_W-1:0]  prio,
    output logic                            found,
    output logic [NUM_W-1:0]                num,
    output logic [PRIO_W-1:0]               pri
);
    always_comb begin
        found = 1'b0;
        num   = '0;
        pri   = '1;
        for (int l = 0; l < LANES; l++) begin
            int idx;
            idx = int'(chunk_idx) * LANES + l;
            if (idx < NUM_IRQ) begin
                if (cand[idx] && (!found || prio[idx] < pri)) begin
                    found = 1'b1;
                    num   = NUM_W'(idx);
                    pri   = prio[idx];
                end
            end
        end
    end
endmodule

// File: rtl/irqsort_core.sv
module irqsort_core
    import irqsort_pkg::*;
#(
    parameter int NUM_IRQ     = 128,
    parameter int PRIO_W      = 6,
    parameter int SORT_CYCLES = 10,
    parameter int STAT_W      = 32,
    localparam int NUM_W      = $clog2(NUM_IRQ)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic               mask_we,
    input  logic [NUM_IRQ-1:0] mask_wdata,
    input  logic               prio_we,
    input  logic [NUM_W-1:0]   prio_idx,
    input  logic [PRIO_W-1:0]  prio_wdata,
    input  logic               ack_we,
    output logic               cpu_irq,
    output logic [STAT_W-1:0]  status_word
);
    localparam int LANES    = (NUM_IRQ + SORT_CYCLES - 1) / SORT_CYCLES;
    localparam int CNT_W    = $clog2(SORT_CYCLES + 1);
    localparam int PRIO_LSB = ((NUM_W + 7) / 8) * 8;
    localparam int SPUR_BIT = STAT_W - 1;

    sort_state_e state_q, state_d;

    logic [NUM_IRQ-1:0]             mask_q;
    logic [NUM_IRQ-1:0][PRIO_W-1:0] prio_q;
    logic [NUM_IRQ-1:0]             snap_q;
    logic [NUM_W-1:0]               trig_q;
    logic [CNT_W-1:0]               cnt_q;
    logic                           drop_q;
    logic                           best_v_q;
    logic [NUM_W-1:0]               best_n_q;
    logic [PRIO_W-1:0]              best_p_q;
    logic [NUM_W-1:0]               act_num_q;
    logic [PRIO_W-1:0]              act_prio_q;
    logic                           act_spur_q;
    logic                           irq_q;

    logic [NUM_IRQ-1:0] pending;
    logic [NUM_IRQ-1:0] mask_eff;
    logic               trig_found;
    logic [NUM_W-1:0]   trig_idx;
    logic               c_found;
    logic [NUM_W-1:0]   c_num;
    logic [PRIO_W-1:0]  c_pri;
    logic               take_chunk;
    logic [NUM_W-1:0]   merge_n;
    logic [PRIO_W-1:0]  merge_p;
    logic               last_scan;
    logic               drop_now;

    assign pending  = irq_req & ~mask_q;
    assign mask_eff = mask_we ? mask_wdata : mask_q;

    irqsort_first #(.NUM_IRQ(NUM_IRQ)) u_first (
        .vec   (pending),
        .found (trig_found),
        .idx   (trig_idx)
    );

    irqsort_chunk #(
        .NUM_IRQ (NUM_IRQ),
        .PRIO_W  (PRIO_W),
        .LANES   (LANES),
        .CNT_W   (CNT_W)
    ) u_chunk (
        .chunk_idx (cnt_q),
        .cand      (snap_q),
        .prio      (prio_q),
        .found     (c_found),
        .num       (c_num),
        .pri       (c_pri)
    );

    assign take_chunk = c_found && (!best_v_q || c_pri < best_p_q);
    assign merge_n    = take_chunk ? c_num : best_n_q;
    assign merge_p    = take_chunk ? c_pri : best_p_q;
    assign last_scan  = (cnt_q == CNT_W'(SORT_CYCLES - 1));
    assign drop_now   = drop_q | ~irq_req[trig_q];

    // Software-visible mask and priority storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '1;
            prio_q <= '0;
        end else begin
            if (mask_we) mask_q <= mask_wdata;
            if (prio_we) prio_q[prio_idx] <= prio_wdata;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (trig_found) state_d = ST_SORT;
            ST_SORT: if (last_scan)  state_d = ST_HOLD;
            ST_HOLD: if (ack_we)     state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q     <= '0;
            trig_q     <= '0;
            cnt_q      <= '0;
            drop_q     <= 1'b0;
            best_v_q   <= 1'b0;
            best_n_q   <= '0;
            best_p_q   <= '0;
            act_num_q  <= '0;
            act_prio_q <= '0;
            act_spur_q <= 1'b0;
            irq_q      <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (trig_found) begin
                        snap_q   <= pending;
                        trig_q   <= trig_idx;
                        cnt_q    <= '0;
                        drop_q   <= 1'b0;
                        best_v_q <= 1'b0;
                        best_n_q <= '0;
                        best_p_q <= '0;
                    end
                end
                ST_SORT: begin
                    cnt_q    <= cnt_q + 1'b1;
                    drop_q   <= drop_now;
                    best_v_q <= best_v_q | c_found;
                    best_n_q <= merge_n;
                    best_p_q <= merge_p;
                    if (last_scan) begin
                        act_num_q  <= merge_n;
                        act_prio_q <= merge_p;
                        act_spur_q <= drop_now | mask_eff[merge_n];
                        irq_q      <= 1'b1;
                    end
                end
                ST_HOLD: if (ack_we) irq_q <= 1'b0;
                default: irq_q <= 1'b0;
            endcase
        end
    end

    assign cpu_irq = irq_q;
    always_comb begin
        status_word = '0;
        status_word[NUM_W-1:0]               = act_num_q;
        status_word[PRIO_LSB +: PRIO_W]      = act_prio_q;
        status_word[SPUR_BIT]                = act_spur_q;
    end

    // Window-length monitor for the assertions
    logic [CNT_W:0] chk_len_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                chk_len_q <= '0;
        else if (state_q == ST_IDLE) chk_len_q <= '0;
        else if (state_q == ST_SORT) chk_len_q <= chk_len_q + 1'b1;
    end

    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq && !ack_we |=> cpu_irq);  // R8
    AST_RESULT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq && !ack_we |=> $stable(status_word));  // R8
    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq && ack_we |=> !cpu_irq);  // R9
    AST_WINDOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_irq) |-> chk_len_q == (CNT_W+1)'(SORT_CYCLES));  // R2
endmodule

// File: tb/irqsort_core_bench.sv
`timescale 1ns/1ps
module irqsort_core_bench;
    localparam int N  = 128;
    localparam int PW = 6;
    localparam int LAT = 11; // negedges from request to visible cpu_irq

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_req = '0;
    logic          mask_we = 1'b0;
    logic [N-1:0]  mask_wdata = '0;
    logic          prio_we = 1'b0;
    logic [6:0]    prio_idx = '0;
    logic [PW-1:0] prio_wdata = '0;
    logic          ack_we = 1'b0;
    logic          cpu_irq;
    logic [31:0]   status_word;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [PW-1:0] prio_m [N];

    always #2.5 clk = ~clk;

    irqsort_core u_irqsort_core (
        .clk, .rst_n, .irq_req, .mask_we, .mask_wdata, .prio_we,
        .prio_idx, .prio_wdata, .ack_we, .cpu_irq, .status_word
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [PW-1:0] pf(input int i);
        return PW'((i * 37 + 11) % 64);
    endfunction

    function automatic int exp_win(input logic [N-1:0] r);
        int w = -1;
        for (int i = 0; i < N; i++)
            if (r[i] && (w < 0 || prio_m[i] < prio_m[w])) w = i;
        return w;
    endfunction

    task automatic wr_prio(input int i, input logic [PW-1:0] p);
        @(negedge clk);
        prio_we = 1'b1; prio_idx = 7'(i); prio_wdata = p;
        @(negedge clk);
        prio_we = 1'b0;
        prio_m[i] = p;
    endtask

    task automatic wr_mask(input logic [N-1:0] m);
        mask_we = 1'b1; mask_wdata = m;
        @(negedge clk);
        mask_we = 1'b0;
    endtask

    task automatic wait_irq(output int lat);
        lat = 0;
        while (!cpu_irq && lat < 40) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic do_ack();
        irq_req = '0; ack_we = 1'b1;
        @(negedge clk);
        ack_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic check_result(input string tag, input int w, input bit spur);
        chk(status_word[6:0] == 7'(w), {tag, " num"}, status_word[6:0], w);
        chk(status_word[13:8] == prio_m[w], {tag, " prio"}, status_word[13:8], prio_m[w]);
        chk(status_word[31] == spur, {tag, " spurious"}, status_word[31], spur);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int lat;
        logic [N-1:0] r;
        logic [31:0] snap;
        for (int i = 0; i < N; i++) prio_m[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state, all lines masked so a request does nothing
        chk(cpu_irq == 1'b0, "R1 irq", cpu_irq, 0);
        chk(status_word == 32'd0, "R1 status", status_word, 0);
        irq_req = '1;
        repeat (15) @(negedge clk);
        chk(cpu_irq == 1'b0, "R1 masked at reset", cpu_irq, 0);
        irq_req = '0;

        for (int i = 0; i < N; i++) wr_prio(i, pf(i));
        @(negedge clk);
        wr_mask('0);

        // R2/R3: single-line sweep over every line
        for (int i = 0; i < N; i++) begin
            r = '0; r[i] = 1'b1;
            irq_req = r;
            wait_irq(lat);
            chk(lat == LAT, "R2 latency", lat, LAT);
            check_result("R3 sweep", i, 1'b0);
            do_ack();
            chk(cpu_irq == 1'b0, "R9 idle after ack", cpu_irq, 0);
        end

        // R3: multi-line patterns, winner computed arithmetically
        for (int k = 1; k <= 20; k++) begin
            r = '0;
            for (int i = 0; i < N; i++) if (((i * k + k * 7) % 11) == 0) r[i] = 1'b1;
            irq_req = r;
            wait_irq(lat);
            chk(lat == LAT, "R2 latency multi", lat, LAT);
            check_result("R3 multi", exp_win(r), 1'b0);
            do_ack();
        end

        // R3: tie goes to the lower number
        wr_prio(20, 6'd2); wr_prio(90, 6'd2); wr_prio(127, 6'd2);
        r = '0; r[127] = 1'b1; r[90] = 1'b1; r[20] = 1'b1;
        irq_req = r;
        wait_irq(lat);
        check_result("R3 tie", 20, 1'b0);
        do_ack();
        wr_prio(20, pf(20)); wr_prio(90, pf(90)); wr_prio(127, pf(127));

        // R4: masked line neither starts nor competes
        wr_prio(50, 6'd0); wr_prio(60, 6'd40);
        r = '0; r[50] = 1'b1;
        @(negedge clk);
        wr_mask(r);
        irq_req = r;
        repeat (15) @(negedge clk);
        chk(cpu_irq == 1'b0, "R4 masked no start", cpu_irq, 0);
        irq_req[60] = 1'b1;
        wait_irq(lat);
        check_result("R4 masked excluded", 60, 1'b0);
        do_ack();
        wr_mask('0);

        // R5: trigger drops mid-window -> spurious
        r = '0; r[5] = 1'b1; r[9] = 1'b1;
        irq_req = r;
        repeat (3) @(negedge clk);
        irq_req[5] = 1'b0;
        wait_irq(lat);
        chk(status_word[31] == 1'b1, "R5 trigger drop spurious", status_word[31], 1);
        chk(status_word[6:0] == 7'(exp_win(r)), "R5 trigger drop num", status_word[6:0], exp_win(r));
        do_ack();
        // R5: dropping a non-trigger line is not spurious
        irq_req = r;
        repeat (3) @(negedge clk);
        irq_req[9] = 1'b0;
        wait_irq(lat);
        check_result("R5 other drop", exp_win(r), 1'b0);
        do_ack();

        // R6: mask the winner mid-window -> spurious
        r = '0; r[3] = 1'b1; r[100] = 1'b1;
        irq_req = r;
        repeat (4) @(negedge clk);
        begin
            logic [N-1:0] m = '0;
            m[exp_win(r)] = 1'b1;
            wr_mask(m);
        end
        wait_irq(lat);
        chk(status_word[31] == 1'b1, "R6 winner masked spurious", status_word[31], 1);
        do_ack();
        wr_mask('0);
        // R6: mask the loser mid-window -> clean result
        irq_req = r;
        repeat (4) @(negedge clk);
        begin
            logic [N-1:0] m = '0;
            m[(exp_win(r) == 3) ? 100 : 3] = 1'b1;
            wr_mask(m);
        end
        wait_irq(lat);
        check_result("R6 loser masked", exp_win(r), 1'b0);
        do_ack();
        wr_mask('0);

        // R7: new urgent request and priority write during window
        wr_prio(41, 6'd0); wr_prio(40, 6'd30);
        r = '0; r[40] = 1'b1;
        irq_req = r;
        repeat (2) @(negedge clk);
        irq_req[41] = 1'b1;
        wait_irq(lat);
        check_result("R7 late request", 40, 1'b0);
        // R8: result held while requests change
        snap = status_word;
        irq_req[0] = 1'b1;
        repeat (6) @(negedge clk);
        chk(cpu_irq == 1'b1, "R8 irq held", cpu_irq, 1);
        chk(status_word == snap, "R8 status frozen", status_word, snap);
        // R9: ack with lines still pending starts a new sort
        irq_req = '0; irq_req[41] = 1'b1;
        ack_we = 1'b1;
        @(negedge clk);
        ack_we = 1'b0;
        chk(cpu_irq == 1'b0, "R9 irq drops on ack", cpu_irq, 0);
        wait_irq(lat);
        chk(lat == LAT, "R9 resort latency", lat, LAT);
        check_result("R9 resort", 41, 1'b0);
        do_ack();
        // R7: priority write during window is not spurious
        irq_req = r;
        @(negedge clk);
        prio_we = 1'b1; prio_idx = 7'd40; prio_wdata = 6'd12;
        @(negedge clk);
        prio_we = 1'b0; prio_m[40] = 6'd12;
        wait_irq(lat);
        chk(status_word[31] == 1'b0, "R7 prio write not spurious", status_word[31], 0);
        chk(status_word[6:0] == 7'd40, "R7 prio write num", status_word[6:0], 40);
        do_ack();

        // R10: ack in idle and during sort is ignored
        ack_we = 1'b1;
        @(negedge clk);
        ack_we = 1'b0;
        chk(cpu_irq == 1'b0, "R10 idle ack", cpu_irq, 0);
        r = '0; r[77] = 1'b1;
        irq_req = r;
        repeat (4) @(negedge clk);
        ack_we = 1'b1;
        @(negedge clk);
        ack_we = 1'b0;
        begin
            int rest;
            wait_irq(rest);
            chk(rest + 5 == LAT, "R10 sort ack ignored", rest + 5, LAT);
        end
        check_result("R10 result", 77, 1'b0);
        do_ack();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule